// File: doc/BRIEF.md
# Run-Time Tap Delay Line With Valid Tracking

This block delays a multi-bit data word by a number of clock-enabled cycles that can be chosen at run time. The word storage is a chain of 32-stage shift segments with no reset. A second, one-bit-wide pipeline does have a reset, moves in step with the words, and reports whether the word at the chosen tap came from a real sample.

A tap-select input picks the read position anywhere along the cascaded segments. Downstream logic uses the valid output to ignore stale or undefined words. Stale words appear while the line primes after reset and again after a run of invalid samples has flushed it. Only the narrow valid path carries reset, so the wide data path stays as plain shift storage.

Top module: `tap_delay_line`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 at every tap position.
- R2: With tap select t, a word accepted on an enabled clock edge appears on `data_o` after t+1 enabled edges. `valid_o` carries the `valid_i` bit that was accepted together with that word.
- R3: Tap select ranges over 0 to NUM_SEG*32-1. The read position follows `tap_i` combinationally, so a new tap value shows on `data_o` and `valid_o` in the same cycle it is applied.
- R4: While `en_i` is low, no stage moves: `data_o` and `valid_o` hold for an unchanged tap, whatever `data_i` and `valid_i` do.
- R5: After reset, `valid_o` is 1 only when at least t+1 enabled edges have occurred since reset, where t is the current tap.
- R6: Feeding `valid_i`=0 flushes the line: at tap t, `valid_o` drops after exactly t+1 enabled edges of invalid input.
- R7: Delays beyond 32 come from whole cascaded segments. A word leaving stage 31 of one segment enters stage 0 of the next, so taps 31, 32 and 63 read consecutive positions.
- R8: Reset clears only valid tracking. Words held in the data segments survive a reset and can still be read, with `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the valid pipeline |
| en_i | input | 1 | Clock enable; the line shifts only when high |
| data_i | input | DATA_W | Data word entering the line |
| valid_i | input | 1 | Marks `data_i` as a real sample |
| tap_i | input | TAP_W | Tap select; delay is tap_i+1 enabled cycles |
| data_o | output | DATA_W | Word at the selected tap |
| valid_o | output | 1 | Valid bit at the selected tap |

## Verification
The assertions take for granted that `tap_i` stays below NUM_SEG*32. With a non-power-of-two segment count, a larger value would index past the line. They also assume that `en_i`, `valid_i` and `tap_i` hold known values at every clock edge after reset. The stimulus drives every input on the falling edge and only ever uses taps from 0 to 63 with the default two segments. It also avoids any tap change that coincides with a reset edge.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int unsigned SEG_LEN = 32;
  localparam int unsigned SEG_AW  = 5;
endpackage

// File: rtl/dl_seg.sv
// One 32-stage data segment, no reset; readable at any stage.
module dl_seg
  import dl_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [SEG_AW-1:0] sel_i,
  output logic [DATA_W-1:0] tap_o,
  output logic [DATA_W-1:0] last_o
);
  logic [DATA_W-1:0] st_q [SEG_LEN];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      st_q[0] <= d_i;
      for (int i = 1; i < SEG_LEN; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign tap_o  = st_q[sel_i];
  assign last_o = st_q[SEG_LEN-1];
endmodule

// File: rtl/dl_vld_pipe.sv
// Resettable valid pipeline, same depth as the data line.
module dl_vld_pipe #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          v_i,
  input  logic [AW-1:0] sel_i,
  output logic          v_o
);
  logic [DEPTH-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   v_q <= '0;
    else if (en_i) v_q <= {v_q[DEPTH-2:0], v_i};
  end

  assign v_o = v_q[sel_i];
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import dl_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_SEG = 2,
  parameter int unsigned TAP_W   = $clog2(NUM_SEG * SEG_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int unsigned DEPTH = NUM_SEG * SEG_LEN;

  logic [DATA_W-1:0] chain   [NUM_SEG+1];
  logic [DATA_W-1:0] seg_tap [NUM_SEG];

  assign chain[0] = data_i;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    dl_seg #(.DATA_W(DATA_W)) u_seg (
      .clk_i (clk_i),
      .en_i  (en_i),
      .d_i   (chain[g]),
      .sel_i (tap_i[SEG_AW-1:0]),
      .tap_o (seg_tap[g]),
      .last_o(chain[g+1])
    );
  end

  if (NUM_SEG > 1) begin : g_multi
    assign data_o = seg_tap[tap_i[TAP_W-1:SEG_AW]];
  end else begin : g_single
    assign data_o = seg_tap[0];
  end

  dl_vld_pipe #(.DEPTH(DEPTH), .AW(TAP_W)) u_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .v_i   (valid_i),
    .sel_i (tap_i),
    .v_o   (valid_o)
  );
endmodule

// File: rtl/tap_delay_line_chk.sv
module tap_delay_line_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_SEG = 2,
  parameter int unsigned TAP_W   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_i,
  input logic [TAP_W-1:0]  tap_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o
);
  localparam int unsigned DEPTH = NUM_SEG * 32;
  localparam logic [TAP_W:0] DEPTH_C = (TAP_W+1)'(DEPTH);
  localparam logic [TAP_W:0] ONE_C   = (TAP_W+1)'(1);

  logic [TAP_W:0] fill_q;
  logic           past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q    <= '0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      if (en_i && fill_q != DEPTH_C) fill_q <= fill_q + ONE_C;
    end
  end

  assert_reset_invalid_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

  assert_tap0_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(en_i) && tap_i == '0)
      |-> (data_o == $past(data_i) && valid_o == $past(valid_i)));

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(en_i) && $stable(tap_i))
      |-> ($stable(data_o) && $stable(valid_o)));

  assert_prime_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, tap_i} < fill_q));

  // R7: one shift moves a word exactly one position, also across segment joins
  assert_step_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(en_i) && ({1'b0, tap_i} == {1'b0, $past(tap_i)} + ONE_C))
      |-> (data_o == $past(data_o) && valid_o == $past(valid_o)));
endmodule

bind tap_delay_line tap_delay_line_chk #(
  .DATA_W (DATA_W),
  .NUM_SEG(NUM_SEG),
  .TAP_W  (TAP_W)
) u_chk (.*);

// File: tb/tb_tap_delay_line.sv
module tb_tap_delay_line;
  localparam int DATA_W = 16;
  localparam int NUM_SEG = 2;
  localparam int DEPTH = NUM_SEG * 32;
  localparam int TAP_W = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              valid_i = 1'b0;
  logic [TAP_W-1:0]  tap_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              valid_o;

  tap_delay_line #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .TAP_W(TAP_W)) dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model: index 0 = most recent accepted word
  logic [DATA_W-1:0] hd [DEPTH];
  logic              hv [DEPTH];
  int fill = 0;
  int total = 0;

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s tap=%0d actual=%h expected=%h", req, tap_i, act, exp);
    end
  endtask

  task automatic push(logic [DATA_W-1:0] d, logic v);
    en_i = 1'b1; data_i = d; valid_i = v;
    @(posedge clk_i); #1;
    for (int i = DEPTH-1; i > 0; i--) begin hd[i] = hd[i-1]; hv[i] = hv[i-1]; end
    hd[0] = d; hv[0] = v;
    if (fill < DEPTH) fill++;
    if (total < DEPTH) total++;
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic look(string req, int t);
    logic ev;
    tap_i = TAP_W'(t); #1;
    ev = (fill > t) ? hv[t] : 1'b0;
    chk(req, DATA_W'(valid_o), DATA_W'(ev));
    if (total > t) chk(req, data_o, hd[t]);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    fill = 0;
    for (int t = 0; t < DEPTH; t += 21) begin
      tap_i = TAP_W'(t); #1;
      chk("R1", DATA_W'(valid_o), '0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_prime();
    do_reset();
    tap_i = 6'd9;
    for (int i = 0; i < 12; i++) begin
      push(DATA_W'(16'h1000 + i), 1'b1);
      tap_i = 6'd9; #1;
      chk("R5", DATA_W'(valid_o), DATA_W'(i >= 9));
    end
    look("R2", 9);
    look("R5", 40); // position not yet filled
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 70; i++) push(DATA_W'(i * 37 + 5), 1'b1);
    for (int t = 0; t < DEPTH; t++) look("R2", t);
    look("R7", 31); look("R7", 32); look("R7", 63);
  endtask

  task automatic t_tapchange();
    push(16'hBEEF, 1'b1);
    push(16'hCAFE, 1'b0);
    tap_i = 6'd0; #1;
    chk("R3", data_o, 16'hCAFE);
    chk("R3", DATA_W'(valid_o), '0);
    tap_i = 6'd1; #1; // no clock between
    chk("R3", data_o, 16'hBEEF);
    chk("R3", DATA_W'(valid_o), 16'd1);
  endtask

  task automatic t_stall();
    logic [DATA_W-1:0] d0;
    logic v0;
    tap_i = 6'd5; #1;
    d0 = data_o; v0 = valid_o;
    for (int i = 0; i < 4; i++) begin
      data_i = DATA_W'(16'h5A00 + i); valid_i = i[0];
      @(negedge clk_i); #1;
      chk("R4", data_o, d0);
      chk("R4", DATA_W'(valid_o), DATA_W'(v0));
    end
    look("R4", 5);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 25; i++) push(DATA_W'(16'h7700 + i), 1'b1);
    for (int i = 1; i <= 21; i++) begin
      push(DATA_W'(16'h3300 + i), 1'b0);
      tap_i = 6'd20; #1;
      chk("R6", DATA_W'(valid_o), DATA_W'(i < 21));
    end
    look("R6", 20);
  endtask

  task automatic t_reset_keep();
    for (int i = 0; i < 40; i++) push(DATA_W'(16'hA000 + i), 1'b1);
    do_reset();
    for (int t = 0; t < 40; t += 7) begin
      tap_i = TAP_W'(t); #1;
      chk("R8", data_o, hd[t]);
      chk("R8", DATA_W'(valid_o), '0);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin hd[i] = '0; hv[i] = 1'b0; end
    t_prime();
    t_sweep();
    t_tapchange();
    t_stall();
    t_flush();
    t_reset_keep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule